// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller runs the refill of one cache line after a miss. It takes a block address, the offset of the missed word and a mode bit. It then fetches all eight words of that block from the memory below, one request per word. Each word that returns goes to its own slot in the line buffer, whatever order it comes back in. The missed word goes to the processor in the same cycle it arrives from memory, so the processor can restart before the rest of the line is filled.

Two fetch orders are available. In wrap mode the first request is for the missed word, and the offsets then climb modulo the block size. In linear mode the words are requested from offset 0 upward, and the missed word is forwarded as soon as it shows up. The controller holds off new misses until the refill is done. It marks the line valid only when every word has been written.

Memory is assumed to return responses in the order they were requested, one word per response beat, with no backpressure on the response side.

Top module: `line_refill_ctrl`

## Requirements
- R1: Each accepted miss produces exactly eight accepted memory requests. Every request carries the missed block address in the address bits above the 3-bit word offset, and each of the eight offsets appears exactly once.
- R2: With `miss_wrap`=1 at acceptance, the request offsets are k, k+1, ... modulo 8, where k is the missed offset.
- R3: With `miss_wrap`=0 at acceptance, the request offsets are 0, 1, ... 7 in that order.
- R4: `cpu_valid` is high in exactly one cycle per refill. That cycle is the one in which the response for the missed offset is on `mem_rsp_data`, and `cpu_data` equals that response. `cpu_valid` and `cpu_data` are combinational from the response.
- R5: Every accepted response is written in its own cycle: `fill_we`=1, `fill_idx` is the offset of that word, and `fill_data` is the response data unchanged.
- R6: `fill_done` is a one-cycle pulse in the cycle right after the eighth response.
- R7: `busy` is high from the cycle after a miss is accepted through the `fill_done` cycle. A miss is accepted only while `busy` is low, and `miss_valid` while busy is ignored.
- R8: `line_valid` is low from the cycle after acceptance up to the `fill_done` cycle. It is high from the `fill_done` cycle until the next accepted miss, and it rises only when all eight offsets have been written.
- R9: After reset `busy`, `line_valid`, `mem_req_valid`, `fill_we`, `cpu_valid` and `fill_done` are all low.
- R10: The mode bit and the miss offset are captured at acceptance. Changing `miss_wrap` during a refill has no effect on that refill's order.
- R11: A request held with `mem_req_ready` low stays valid, with the same address, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_blk | input | BLK_W | Block address of the miss |
| miss_off | input | 3 | Offset of the missed word |
| miss_wrap | input | 1 | 1 = wrap order from the missed word, 0 = linear order |
| busy | output | 1 | Refill in progress |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | BLK_W+3 | Word address {block, offset} |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_data | input | 32 | Response word |
| fill_we | output | 1 | Line buffer write strobe |
| fill_idx | output | 3 | Line buffer word slot |
| fill_data | output | 32 | Line buffer write data |
| cpu_valid | output | 1 | Missed word returned to the processor |
| cpu_data | output | 32 | Missed word |
| fill_done | output | 1 | Refill complete pulse |
| line_valid | output | 1 | Line fully written |

## Verification
The bound checker watches every cycle for the following: the block address on each request, the offset of the first request in each mode, forwarding only alongside a write to the captured missed slot, the one-cycle done pulse after exactly eight writes, silence while idle, no write to a line already marked valid, and stable held requests. The full request order, the data written to each slot, the position of the forwarded word within the fill, the ignored second miss and the mode change during a refill can only be shown by the bench's scenarios, which compare against an independent memory model under both steady and stalling handshakes.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DONE
    } fill_state_e;

endpackage

// File: rtl/refill_seq.sv
// Offset generator: maps a step count to a word offset for either fetch order.
module refill_seq #(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] base,
    input  logic [OFF_W-1:0] step,
    input  logic             wrap,
    output logic [OFF_W-1:0] off
);
    always_comb begin
        // modulo arithmetic comes from the OFF_W-wide result
        off = wrap ? (base + step) : step;
    end
endmodule

// File: rtl/refill_route.sv
// Routes a returning word to the line buffer and, if it is the missed one, to the processor.
module refill_route #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 3
) (
    input  logic              accept,
    input  logic [OFF_W-1:0]  rsp_off,
    input  logic [OFF_W-1:0]  crit_off,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              fill_we,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [DATA_W-1:0] fill_data,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data
);
    always_comb begin
        fill_we   = accept;
        fill_idx  = rsp_off;
        fill_data = rsp_data;
        cpu_valid = accept && (rsp_off == crit_off);
        cpu_data  = rsp_data;
    end
endmodule

// File: rtl/refill_fsm.sv
// Refill sequencer: captures the miss, counts requests and responses, tracks written slots.
module refill_fsm
    import refill_pkg::*;
#(
    parameter int BLK_W = 26,
    parameter int WORDS = 8,
    parameter int OFF_W = $clog2(WORDS),
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [BLK_W-1:0] miss_blk,
    input  logic [OFF_W-1:0] miss_off,
    input  logic             miss_wrap,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [OFF_W-1:0] rsp_off,
    output logic             busy,
    output logic             req_valid,
    output logic [OFF_W-1:0] req_step,
    output logic [OFF_W-1:0] rsp_step,
    output logic             rsp_accept,
    output logic [BLK_W-1:0] cur_blk,
    output logic [OFF_W-1:0] crit_off,
    output logic             cur_wrap,
    output logic             fill_done,
    output logic             line_valid
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORDS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORDS - 1);

    typedef struct packed {
        fill_state_e      st;
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] crit;
        logic             wrap;
        logic [CNT_W-1:0] req_cnt;
        logic [CNT_W-1:0] rsp_cnt;
        logic [WORDS-1:0] mask;
        logic             lv;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic req_fire;

    always_comb begin
        busy       = (ctx_q.st != ST_IDLE);
        req_valid  = (ctx_q.st == ST_FILL) && (ctx_q.req_cnt < CNT_FULL);
        rsp_accept = (ctx_q.st == ST_FILL) && rsp_valid && (ctx_q.rsp_cnt < CNT_FULL);
        req_step   = ctx_q.req_cnt[OFF_W-1:0];
        rsp_step   = ctx_q.rsp_cnt[OFF_W-1:0];
        cur_blk    = ctx_q.blk;
        crit_off   = ctx_q.crit;
        cur_wrap   = ctx_q.wrap;
        fill_done  = (ctx_q.st == ST_DONE);
        line_valid = ctx_q.lv;
        req_fire   = req_valid && req_ready;
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    ctx_d.st      = ST_FILL;
                    ctx_d.blk     = miss_blk;
                    ctx_d.crit    = miss_off;
                    ctx_d.wrap    = miss_wrap;
                    ctx_d.req_cnt = '0;
                    ctx_d.rsp_cnt = '0;
                    ctx_d.mask    = '0;
                    ctx_d.lv      = 1'b0;
                end
            end
            ST_FILL: begin
                if (req_fire) begin
                    ctx_d.req_cnt = ctx_q.req_cnt + 1'b1;
                end
                if (rsp_accept) begin
                    ctx_d.rsp_cnt       = ctx_q.rsp_cnt + 1'b1;
                    ctx_d.mask[rsp_off] = 1'b1;
                    if (ctx_q.rsp_cnt == CNT_LAST) begin
                        ctx_d.st = ST_DONE;
                        ctx_d.lv = &ctx_d.mask;
                    end
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl #(
    parameter int BLK_W  = 26,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(WORDS),
    parameter int ADDR_W = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [BLK_W-1:0]  miss_blk,
    input  logic [OFF_W-1:0]  miss_off,
    input  logic              miss_wrap,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              fill_we,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [DATA_W-1:0] fill_data,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data,
    output logic              fill_done,
    output logic              line_valid
);
    logic [OFF_W-1:0] req_step, rsp_step, req_off, rsp_off, crit_off;
    logic [BLK_W-1:0] cur_blk;
    logic             cur_wrap, rsp_accept;

    refill_fsm #(.BLK_W(BLK_W), .WORDS(WORDS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_blk   (miss_blk),
        .miss_off   (miss_off),
        .miss_wrap  (miss_wrap),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_off    (rsp_off),
        .busy       (busy),
        .req_valid  (mem_req_valid),
        .req_step   (req_step),
        .rsp_step   (rsp_step),
        .rsp_accept (rsp_accept),
        .cur_blk    (cur_blk),
        .crit_off   (crit_off),
        .cur_wrap   (cur_wrap),
        .fill_done  (fill_done),
        .line_valid (line_valid)
    );

    refill_seq #(.OFF_W(OFF_W)) u_req_seq (
        .base (crit_off),
        .step (req_step),
        .wrap (cur_wrap),
        .off  (req_off)
    );

    refill_seq #(.OFF_W(OFF_W)) u_rsp_seq (
        .base (crit_off),
        .step (rsp_step),
        .wrap (cur_wrap),
        .off  (rsp_off)
    );

    refill_route #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_route (
        .accept    (rsp_accept),
        .rsp_off   (rsp_off),
        .crit_off  (crit_off),
        .rsp_data  (mem_rsp_data),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_data (fill_data),
        .cpu_valid (cpu_valid),
        .cpu_data  (cpu_data)
    );

    assign mem_req_addr = {cur_blk, req_off};
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
    parameter int BLK_W  = 26,
    parameter int WORDS  = 8,
    parameter int OFF_W  = $clog2(WORDS),
    parameter int ADDR_W = BLK_W + OFF_W,
    parameter int CNT_W  = $clog2(WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [BLK_W-1:0]  miss_blk,
    input logic [OFF_W-1:0]  miss_off,
    input logic              miss_wrap,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              fill_we,
    input logic [OFF_W-1:0]  fill_idx,
    input logic              cpu_valid,
    input logic              fill_done,
    input logic              line_valid
);
    logic [BLK_W-1:0] blk_c;
    logic [OFF_W-1:0] off_c;
    logic             wrap_c;
    logic [CNT_W-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_c  <= '0;
            off_c  <= '0;
            wrap_c <= 1'b0;
            wr_cnt <= '0;
        end else if (miss_valid && !busy) begin
            blk_c  <= miss_blk;
            off_c  <= miss_off;
            wrap_c <= miss_wrap;
            wr_cnt <= '0;
        end else if (fill_we) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    a_r1_req_block: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ADDR_W-1:OFF_W] == blk_c);

    // R2 and R3: first request offset depends on the captured mode (R10)
    a_r2_first_offset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req_valid &&
            (mem_req_addr[OFF_W-1:0] == (wrap_c ? off_c : {OFF_W{1'b0}})));

    a_r4_forward_slot: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> fill_we && (fill_idx == off_c));

    a_r6_eight_writes: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> wr_cnt == CNT_W'(WORDS));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !fill_we && !cpu_valid);

    a_r8_no_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !line_valid);

    a_r8_valid_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> fill_done);

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind line_refill_ctrl refill_checker #(.BLK_W(BLK_W), .WORDS(WORDS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_blk      (miss_blk),
    .miss_off      (miss_off),
    .miss_wrap     (miss_wrap),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fill_we       (fill_we),
    .fill_idx      (fill_idx),
    .cpu_valid     (cpu_valid),
    .fill_done     (fill_done),
    .line_valid    (line_valid)
);

// File: tb/tb_line_refill_ctrl.sv
`timescale 1ns/1ps
module tb_line_refill_ctrl;
    localparam int BLK_W  = 26;
    localparam int OFF_W  = 3;
    localparam int ADDR_W = BLK_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [BLK_W-1:0]  miss_blk = '0;
    logic [OFF_W-1:0]  miss_off = '0;
    logic              miss_wrap = 1'b0;
    logic              busy;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              fill_we;
    logic [OFF_W-1:0]  fill_idx;
    logic [31:0]       fill_data;
    logic              cpu_valid;
    logic [31:0]       cpu_data;
    logic              fill_done;
    logic              line_valid;

    always #2 clk = ~clk;

    line_refill_ctrl dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
        .miss_off(miss_off), .miss_wrap(miss_wrap), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_we(fill_we), .fill_idx(fill_idx),
        .fill_data(fill_data), .cpu_valid(cpu_valid), .cpu_data(cpu_data),
        .fill_done(fill_done), .line_valid(line_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit done_seen = 1'b0;
    bit prev_done = 1'b0;
    int wcnt = 0;
    int cpu_cnt = 0;
    int exp_cpu_pos = 0;
    logic [31:0] exp_cpu_data = '0;

    logic [ADDR_W-1:0] req_q[$];
    logic [ADDR_W-1:0] pend_q[$];
    logic [OFF_W-1:0]  fidx_q[$];
    logic [31:0]       fdat_q[$];

    function automatic logic [31:0] wdata(input logic [ADDR_W-1:0] a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0001_0193);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: in-order responses, optional stalls on both sides
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            mem_req_ready = !stall_mode || (cyc % 3 != 0);
            if (pend_q.size() > 0 && !(stall_mode && cyc[0])) begin
                logic [ADDR_W-1:0] a;
                a = pend_q.pop_front();
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = wdata(a);
            end
            #1;
            if (rst_n && mem_req_valid && mem_req_ready) pend_q.push_back(mem_req_addr);
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (mem_req_valid && mem_req_ready) begin
                    logic [ADDR_W-1:0] e;
                    e = (req_q.size() > 0) ? req_q.pop_front() : '1;
                    chk(mem_req_addr == e, "R1 R2 R3 R10 request address/order", mem_req_addr, e);
                end
                if (cpu_valid) begin
                    chk(cpu_data == exp_cpu_data, "R4 forwarded data", cpu_data, exp_cpu_data);
                    chk(wcnt == exp_cpu_pos, "R4 forwarded at arrival position", wcnt, exp_cpu_pos);
                    cpu_cnt++;
                end
                if (fill_we) begin
                    logic [OFF_W-1:0] ei;
                    logic [31:0] ed;
                    ei = (fidx_q.size() > 0) ? fidx_q.pop_front() : '1;
                    ed = (fdat_q.size() > 0) ? fdat_q.pop_front() : '1;
                    chk(fill_idx == ei, "R5 fill slot", fill_idx, ei);
                    chk(fill_data == ed, "R5 fill data", fill_data, ed);
                    chk(!line_valid, "R8 line invalid while filling", line_valid, 0);
                    wcnt++;
                end
                if (fill_done) begin
                    chk(wcnt == 8, "R6 done after eighth word", wcnt, 8);
                    chk(!prev_done, "R6 single-cycle pulse", prev_done, 0);
                    chk(line_valid, "R8 valid at done", line_valid, 1);
                    chk(busy, "R7 busy through done", busy, 1);
                    done_seen = 1'b1;
                end
                prev_done = fill_done;
            end
        end
    end

    task automatic run_refill(input logic [BLK_W-1:0] blk, input logic [OFF_W-1:0] off,
                              input bit wrap, input bit stall, input bit poke);
        wcnt = 0;
        cpu_cnt = 0;
        done_seen = 1'b0;
        stall_mode = stall;
        for (int i = 0; i < 8; i++) begin
            logic [OFF_W-1:0] o;
            o = wrap ? OFF_W'(off + OFF_W'(i)) : OFF_W'(i);
            req_q.push_back({blk, o});
            fidx_q.push_back(o);
            fdat_q.push_back(wdata({blk, o}));
            if (o == off) exp_cpu_pos = i;
        end
        exp_cpu_data = wdata({blk, off});
        @(negedge clk);
        miss_valid = 1'b1;
        miss_blk   = blk;
        miss_off   = off;
        miss_wrap  = wrap;
        @(negedge clk);
        miss_valid = 1'b0;
        miss_wrap  = !wrap;   // R10: mode change mid-refill must not matter
        #1;
        chk(busy, "R7 busy after accept", busy, 1);
        chk(!line_valid, "R8 valid cleared on accept", line_valid, 0);
        if (poke) begin
            // R7: a second miss while busy is ignored
            @(negedge clk);
            miss_valid = 1'b1;
            miss_blk   = ~blk;
            miss_off   = off + 3'd3;
            @(negedge clk);
            miss_valid = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        #1;
        chk(!busy, "R7 busy low after done", busy, 0);
        chk(line_valid, "R8 valid held after done", line_valid, 1);
        chk(!mem_req_valid, "R7 no request when idle (ignored miss)", mem_req_valid, 0);
        chk(req_q.size() == 0, "R1 all eight requests issued", req_q.size(), 0);
        chk(fidx_q.size() == 0, "R5 all eight slots written", fidx_q.size(), 0);
        chk(cpu_cnt == 1, "R4 exactly one forward", cpu_cnt, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !line_valid && !mem_req_valid, "R9 reset outputs", {busy, line_valid, mem_req_valid}, 0);
        chk(!fill_we && !cpu_valid && !fill_done, "R9 reset strobes", {fill_we, cpu_valid, fill_done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_refill(26'h123_4567, 3'd5, 1'b1, 1'b0, 1'b0); // R2 wrap from middle
        run_refill(26'h000_0001, 3'd0, 1'b1, 1'b1, 1'b1); // R2 from zero, stalls, R7 poke
        run_refill(26'h3FF_FFFF, 3'd7, 1'b1, 1'b1, 1'b0); // R2 wrap from last
        run_refill(26'h0AB_CDEF, 3'd0, 1'b0, 1'b0, 1'b0); // R3 linear, first word
        run_refill(26'h155_5555, 3'd7, 1'b0, 1'b1, 1'b1); // R3 linear, last word
        run_refill(26'h2AA_AAAA, 3'd3, 1'b0, 1'b0, 1'b1); // R3 linear, middle
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule